// File: doc/BRIEF.md
# Dual-Issue Hazard-Screened Instruction Picker

This block looks at a small window of waiting instructions and, each cycle, picks up to two of them to send to two ALUs. Each window entry carries a valid flag, a class bit (plain operation or load/store), two source register numbers and one destination register number. Three more inputs shape the choice: a mask of registers still owed by loads in flight, and the free-slot counts of the operation result buffer and the load/store buffer.

The window is scanned from the oldest entry (index 0) to the youngest. Two register masks are kept during the scan: a "no-read" mask and a "no-write" mask. Both start out equal to the pending-load mask. An entry is picked only if it reads nothing in the no-read mask, writes nothing in the no-write mask, fits its class budget, respects load/store ordering, and fewer than two entries have been picked so far. A picked entry puts its destination in the no-read mask. An entry that is passed over puts its destination in the no-read mask and its sources and destination in the no-write mask. This way every skipped entry is protected until it is issued later. Younger entries may overtake older ones that were passed over.

The selection is computed from the inputs of one cycle and shows up on the registered outputs after the next rising clock edge. The outputs are two grant ports and a removal mask that tells the window which entries were taken.

Top module: `dual_pick`

## Requirements
- R1: While `rst` is high, both grant valids and the removal mask are zero at the next clock edge.
- R2: An entry whose source is set in `pend_mask`, or whose destination is set in `pend_mask`, is not granted.
- R3: At most two entries are granted per cycle, and the result appears one cycle after the inputs. If `gnt1_vld` is high then `gnt0_vld` is high, and `gnt0_idx` is below `gnt1_idx`, where index 0 is the oldest entry.
- R4: A younger entry with no conflict is granted even when an older entry is passed over.
- R5: A later entry that reads the destination of an entry granted earlier in the same cycle is not granted.
- R6: A later entry may be granted when it writes the same register as the destination of an earlier grant, or a source register of an earlier grant.
- R7: After an entry is passed over, a later entry that reads its destination is not granted, and a later entry that writes one of its sources or its destination is not granted.
- R8: Load/store entries (`cand_cls` bit = 1) issue in order. Once one load/store entry is passed over, every younger load/store entry in the same cycle is passed over too.
- R9: The grants of class operation (`cand_cls` bit = 0) in a cycle never exceed `op_free`, and the grants of class load/store never exceed `lsu_free`. An entry over its class budget counts as passed over and applies the R7 protection.
- R10: `remove_mask` has exactly the bits of the granted indices set.
- R11: Entries with `cand_valid` low are never granted and do not change the no-read or no-write masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_valid | input | WIN | Entry holds an instruction |
| cand_cls | input | WIN | Class per entry: 0 operation, 1 load/store |
| cand_rs0 | input | WIN x RW | First source register per entry |
| cand_rs1 | input | WIN x RW | Second source register per entry |
| cand_rd | input | WIN x RW | Destination register per entry |
| pend_mask | input | NREG | Registers owed by loads in flight |
| op_free | input | CW | Free slots in the operation result buffer |
| lsu_free | input | CW | Free slots in the load/store buffer |
| gnt0_vld | output | 1 | Grant to ALU 0 valid (older winner) |
| gnt0_idx | output | IW | Window index of grant 0 |
| gnt1_vld | output | 1 | Grant to ALU 1 valid (younger winner) |
| gnt1_idx | output | IW | Window index of grant 1 |
| remove_mask | output | WIN | Entries taken this cycle |

## Verification
The hardest case to reach from the ports is a passed-over entry whose protection decides the fate of a younger entry. One such case is a write into a register that an older skipped entry still has to read. Another is an entry that lost only because of its class budget, yet still blocks later entries. The directed windows are built so that an older entry is blocked first, either by `pend_mask` or by a zero budget. The following entries then each touch one specific register of that blocked entry, so every grant or miss points to one rule. Windows where an earlier grant shares a destination or a source with a later entry show that winners do not over-protect.

// File: rtl/dual_pick_pkg.sv
package dual_pick_pkg;
    localparam logic CLS_OP  = 1'b0;
    localparam logic CLS_LSU = 1'b1;
    localparam int   MAX_GRANTS = 2;
endpackage

// File: rtl/dual_pick_scan.sv
module dual_pick_scan #(
    parameter int WIN  = 4,
    parameter int NREG = 32,
    parameter int CW   = 2,
    localparam int RW  = $clog2(NREG)
) (
    input  logic [WIN-1:0]         cand_valid,
    input  logic [WIN-1:0]         cand_cls,
    input  logic [WIN-1:0][RW-1:0] cand_rs0,
    input  logic [WIN-1:0][RW-1:0] cand_rs1,
    input  logic [WIN-1:0][RW-1:0] cand_rd,
    input  logic [NREG-1:0]        pend_mask,
    input  logic [CW-1:0]          op_free,
    input  logic [CW-1:0]          lsu_free,
    output logic [WIN-1:0]         win_vec
);
    import dual_pick_pkg::*;

    logic [WIN-1:0][NREG-1:0] src_oh;
    logic [WIN-1:0][NREG-1:0] dst_oh;

    for (genvar g = 0; g < WIN; g++) begin : g_dec
        assign src_oh[g] = (NREG'(1) << cand_rs0[g]) | (NREG'(1) << cand_rs1[g]);
        assign dst_oh[g] = NREG'(1) << cand_rd[g];
    end

    logic [NREG-1:0] no_rd;
    logic [NREG-1:0] no_wr;
    logic            lsu_hold;
    logic [CW-1:0]   op_n;
    logic [CW-1:0]   lsu_n;
    logic [1:0]      n_win;
    logic            is_lsu;
    logic            room;
    logic            clash;

    always_comb begin
        no_rd    = pend_mask;
        no_wr    = pend_mask;
        lsu_hold = 1'b0;
        op_n     = '0;
        lsu_n    = '0;
        n_win    = '0;
        is_lsu   = 1'b0;
        room     = 1'b0;
        clash    = 1'b0;
        win_vec  = '0;
        for (int i = 0; i < WIN; i++) begin
            if (cand_valid[i]) begin
                is_lsu = (cand_cls[i] == CLS_LSU);
                room   = is_lsu ? (lsu_n < lsu_free) : (op_n < op_free);
                clash  = ((no_rd & src_oh[i]) != '0) || ((no_wr & dst_oh[i]) != '0);
                if (!clash && room && (int'(n_win) < MAX_GRANTS) && !(is_lsu && lsu_hold)) begin
                    win_vec[i] = 1'b1;
                    n_win      = n_win + 2'd1;
                    if (is_lsu) lsu_n = lsu_n + CW'(1);
                    else        op_n  = op_n + CW'(1);
                    no_rd      = no_rd | dst_oh[i];
                end else begin
                    no_rd = no_rd | dst_oh[i];
                    no_wr = no_wr | dst_oh[i] | src_oh[i];
                    if (is_lsu) lsu_hold = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dual_pick_enc.sv
module dual_pick_enc #(
    parameter int WIN = 4,
    localparam int IW = $clog2(WIN)
) (
    input  logic [WIN-1:0] win_vec,
    output logic           g0_vld,
    output logic [IW-1:0]  g0_idx,
    output logic           g1_vld,
    output logic [IW-1:0]  g1_idx
);
    always_comb begin
        g0_vld = 1'b0;
        g0_idx = '0;
        g1_vld = 1'b0;
        g1_idx = '0;
        for (int i = 0; i < WIN; i++) begin
            if (win_vec[i]) begin
                if (!g0_vld) begin
                    g0_vld = 1'b1;
                    g0_idx = IW'(i);
                end else if (!g1_vld) begin
                    g1_vld = 1'b1;
                    g1_idx = IW'(i);
                end
            end
        end
    end
endmodule

// File: rtl/dual_pick.sv
module dual_pick #(
    parameter int WIN  = 4,
    parameter int NREG = 32,
    parameter int CW   = 2,
    localparam int RW  = $clog2(NREG),
    localparam int IW  = $clog2(WIN)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [WIN-1:0]         cand_valid,
    input  logic [WIN-1:0]         cand_cls,
    input  logic [WIN-1:0][RW-1:0] cand_rs0,
    input  logic [WIN-1:0][RW-1:0] cand_rs1,
    input  logic [WIN-1:0][RW-1:0] cand_rd,
    input  logic [NREG-1:0]        pend_mask,
    input  logic [CW-1:0]          op_free,
    input  logic [CW-1:0]          lsu_free,
    output logic                   gnt0_vld,
    output logic [IW-1:0]          gnt0_idx,
    output logic                   gnt1_vld,
    output logic [IW-1:0]          gnt1_idx,
    output logic [WIN-1:0]         remove_mask
);
    typedef struct packed {
        logic           g0_vld;
        logic [IW-1:0]  g0_idx;
        logic           g1_vld;
        logic [IW-1:0]  g1_idx;
        logic [WIN-1:0] rm;
    } pick_t;

    logic [WIN-1:0] win_vec;
    logic           e0_vld, e1_vld;
    logic [IW-1:0]  e0_idx, e1_idx;
    pick_t          pick_d, pick_q;

    dual_pick_scan #(.WIN(WIN), .NREG(NREG), .CW(CW)) u_scan (
        .cand_valid (cand_valid),
        .cand_cls   (cand_cls),
        .cand_rs0   (cand_rs0),
        .cand_rs1   (cand_rs1),
        .cand_rd    (cand_rd),
        .pend_mask  (pend_mask),
        .op_free    (op_free),
        .lsu_free   (lsu_free),
        .win_vec    (win_vec)
    );

    dual_pick_enc #(.WIN(WIN)) u_enc (
        .win_vec (win_vec),
        .g0_vld  (e0_vld),
        .g0_idx  (e0_idx),
        .g1_vld  (e1_vld),
        .g1_idx  (e1_idx)
    );

    always_comb begin
        pick_d        = '0;
        pick_d.g0_vld = e0_vld;
        pick_d.g0_idx = e0_idx;
        pick_d.g1_vld = e1_vld;
        pick_d.g1_idx = e1_idx;
        pick_d.rm     = win_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) pick_q <= '0;
        else     pick_q <= pick_d;
    end

    assign gnt0_vld    = pick_q.g0_vld;
    assign gnt0_idx    = pick_q.g0_idx;
    assign gnt1_vld    = pick_q.g1_vld;
    assign gnt1_idx    = pick_q.g1_idx;
    assign remove_mask = pick_q.rm;
endmodule

// File: rtl/dual_pick_check.sv
module dual_pick_check #(
    parameter int WIN  = 4,
    parameter int NREG = 32,
    parameter int CW   = 2,
    localparam int RW  = $clog2(NREG),
    localparam int IW  = $clog2(WIN)
) (
    input logic                   clk,
    input logic                   rst,
    input logic [WIN-1:0]         cand_valid,
    input logic [WIN-1:0]         cand_cls,
    input logic [WIN-1:0][RW-1:0] cand_rs0,
    input logic [WIN-1:0][RW-1:0] cand_rs1,
    input logic [WIN-1:0][RW-1:0] cand_rd,
    input logic [NREG-1:0]        pend_mask,
    input logic [CW-1:0]          op_free,
    input logic [CW-1:0]          lsu_free,
    input logic                   gnt0_vld,
    input logic [IW-1:0]          gnt0_idx,
    input logic                   gnt1_vld,
    input logic [IW-1:0]          gnt1_idx,
    input logic [WIN-1:0]         remove_mask
);
    logic [WIN-1:0]         val_q, cls_q;
    logic [WIN-1:0][RW-1:0] rs0_q, rs1_q, rd_q;
    logic [NREG-1:0]        pend_q;
    logic [CW-1:0]          opf_q, lsuf_q;

    always_ff @(posedge clk) begin
        val_q  <= cand_valid;
        cls_q  <= cand_cls;
        rs0_q  <= cand_rs0;
        rs1_q  <= cand_rs1;
        rd_q   <= cand_rd;
        pend_q <= pend_mask;
        opf_q  <= op_free;
        lsuf_q <= lsu_free;
    end

    int n_lsu, n_op;
    always_comb begin
        n_lsu = 0;
        n_op  = 0;
        if (gnt0_vld) begin
            if (cls_q[gnt0_idx]) n_lsu++; else n_op++;
        end
        if (gnt1_vld) begin
            if (cls_q[gnt1_idx]) n_lsu++; else n_op++;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!gnt0_vld && !gnt1_vld && remove_mask == '0));

    assert_port_order_R3: assert property (@(posedge clk) disable iff (rst)
        gnt1_vld |-> (gnt0_vld && gnt0_idx < gnt1_idx));

    assert_pending_block_R2: assert property (@(posedge clk) disable iff (rst)
        gnt0_vld |-> (!pend_q[rs0_q[gnt0_idx]] && !pend_q[rs1_q[gnt0_idx]] && !pend_q[rd_q[gnt0_idx]]));

    assert_same_cycle_raw_R5: assert property (@(posedge clk) disable iff (rst)
        gnt1_vld |-> (rd_q[gnt0_idx] != rs0_q[gnt1_idx] && rd_q[gnt0_idx] != rs1_q[gnt1_idx]));

    assert_class_budget_R9: assert property (@(posedge clk) disable iff (rst)
        (n_lsu <= int'(lsuf_q)) && (n_op <= int'(opf_q)));

    assert_mask_count_R10: assert property (@(posedge clk) disable iff (rst)
        $countones(remove_mask) == int'(gnt0_vld) + int'(gnt1_vld));

    assert_mask_match_R10: assert property (@(posedge clk) disable iff (rst)
        gnt0_vld |-> remove_mask[gnt0_idx]);

    assert_valid_only_R11: assert property (@(posedge clk) disable iff (rst)
        (remove_mask & ~val_q) == '0);
endmodule

bind dual_pick dual_pick_check #(.WIN(WIN), .NREG(NREG), .CW(CW)) u_chk (.*);

// File: tb/sim_dual_pick.sv
module sim_dual_pick;
    localparam int WIN = 4, NREG = 32, CW = 2;
    localparam int RW = $clog2(NREG), IW = $clog2(WIN);

    logic                   clk = 1'b0;
    logic                   rst;
    logic [WIN-1:0]         cand_valid, cand_cls;
    logic [WIN-1:0][RW-1:0] cand_rs0, cand_rs1, cand_rd;
    logic [NREG-1:0]        pend_mask;
    logic [CW-1:0]          op_free, lsu_free;
    logic                   gnt0_vld, gnt1_vld;
    logic [IW-1:0]          gnt0_idx, gnt1_idx;
    logic [WIN-1:0]         remove_mask;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    dual_pick #(.WIN(WIN), .NREG(NREG), .CW(CW)) u0 (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_win();
        cand_valid = '0; cand_cls = '0;
        cand_rs0 = '0; cand_rs1 = '0; cand_rd = '0;
        pend_mask = '0; op_free = 2'd3; lsu_free = 2'd3;
    endtask

    task automatic put(input int i, input logic lsu, input int a, input int b, input int d);
        cand_valid[i] = 1'b1;
        cand_cls[i]   = lsu;
        cand_rs0[i]   = RW'(a);
        cand_rs1[i]   = RW'(b);
        cand_rd[i]    = RW'(d);
    endtask

    task automatic expect_out(input string req, input int v0, input int i0,
                              input int v1, input int i1, input int m);
        @(negedge clk);
        chk({req, " g0_vld"}, int'(gnt0_vld), v0);
        if (v0 != 0) chk({req, " g0_idx"}, int'(gnt0_idx), i0);
        chk({req, " g1_vld"}, int'(gnt1_vld), v1);
        if (v1 != 0) chk({req, " g1_idx"}, int'(gnt1_idx), i1);
        chk({req, " remove_mask"}, int'(remove_mask), m);
    endtask

    task automatic t_reset();
        @(negedge clk); clear_win(); rst = 1'b1;
        put(0, 1'b0, 1, 2, 3); put(1, 1'b0, 4, 5, 6);
        @(negedge clk);
        chk("R1 g0_vld", int'(gnt0_vld), 0);
        chk("R1 g1_vld", int'(gnt1_vld), 0);
        chk("R1 remove_mask", int'(remove_mask), 0);
        rst = 1'b0;
    endtask

    task automatic t_seed();
        @(negedge clk); clear_win(); pend_mask[1] = 1'b1;
        put(0, 1'b0, 1, 3, 4);
        put(1, 1'b0, 5, 6, 1);
        put(2, 1'b0, 7, 8, 9);
        put(3, 1'b0, 10, 11, 12);
        expect_out("R2", 1, 2, 1, 3, 4'b1100);
    endtask

    task automatic t_loser_protect();
        @(negedge clk); clear_win(); pend_mask[2] = 1'b1;
        put(0, 1'b0, 2, 3, 4);
        put(1, 1'b0, 4, 5, 6);
        put(2, 1'b0, 7, 8, 3);
        put(3, 1'b0, 9, 10, 11);
        expect_out("R7 R4", 1, 3, 0, 0, 4'b1000);
    endtask

    task automatic t_raw();
        @(negedge clk); clear_win();
        put(0, 1'b0, 1, 2, 3);
        put(1, 1'b0, 3, 4, 5);
        put(2, 1'b0, 6, 7, 8);
        expect_out("R5", 1, 0, 1, 2, 4'b0101);
    endtask

    task automatic t_waw();
        @(negedge clk); clear_win();
        put(0, 1'b0, 1, 2, 3);
        put(1, 1'b0, 4, 5, 3);
        expect_out("R6 waw", 1, 0, 1, 1, 4'b0011);
    endtask

    task automatic t_war();
        @(negedge clk); clear_win();
        put(0, 1'b0, 1, 2, 3);
        put(2, 1'b0, 4, 5, 1);
        expect_out("R6 war", 1, 0, 1, 2, 4'b0101);
    endtask

    task automatic t_cap();
        @(negedge clk); clear_win();
        for (int i = 0; i < WIN; i++) put(i, 1'b0, 4*i+1, 4*i+2, 4*i+3);
        expect_out("R3 cap", 1, 0, 1, 1, 4'b0011);
    endtask

    task automatic t_lsu_order();
        @(negedge clk); clear_win(); pend_mask[2] = 1'b1;
        put(0, 1'b1, 2, 2, 3);
        put(1, 1'b1, 5, 5, 6);
        put(2, 1'b0, 7, 8, 9);
        put(3, 1'b1, 10, 10, 11);
        expect_out("R8", 1, 2, 0, 0, 4'b0100);
    endtask

    task automatic t_budget_a();
        @(negedge clk); clear_win(); op_free = 2'd1;
        put(0, 1'b0, 1, 2, 3);
        put(1, 1'b0, 4, 5, 6);
        put(2, 1'b1, 7, 7, 8);
        expect_out("R9 op", 1, 0, 1, 2, 4'b0101);
    endtask

    task automatic t_budget_b();
        @(negedge clk); clear_win(); op_free = 2'd0; lsu_free = 2'd1;
        put(0, 1'b0, 1, 2, 3);
        put(1, 1'b1, 9, 9, 10);
        put(2, 1'b1, 11, 11, 12);
        put(3, 1'b0, 13, 14, 15);
        expect_out("R9 lsu", 1, 1, 0, 0, 4'b0010);
    endtask

    task automatic t_budget_protect();
        @(negedge clk); clear_win(); op_free = 2'd1;
        put(0, 1'b0, 1, 2, 3);
        put(1, 1'b0, 4, 5, 6);
        put(2, 1'b1, 6, 6, 8);
        expect_out("R9 protect", 1, 0, 0, 0, 4'b0001);
    endtask

    task automatic t_invalid();
        @(negedge clk); clear_win();
        put(0, 1'b0, 2, 3, 1);
        cand_valid[0] = 1'b0;
        put(1, 1'b0, 1, 2, 3);
        put(2, 1'b0, 4, 5, 6);
        expect_out("R11", 1, 1, 1, 2, 4'b0110);
    endtask

    task automatic t_idle();
        @(negedge clk); clear_win();
        expect_out("R10 idle", 0, 0, 0, 0, 4'b0000);
    endtask

    initial begin
        #(20 * 20000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        clear_win();
        repeat (2) @(negedge clk);
        t_reset();
        t_seed();
        t_loser_protect();
        t_raw();
        t_waw();
        t_war();
        t_cap();
        t_lsu_order();
        t_budget_a();
        t_budget_b();
        t_budget_protect();
        t_invalid();
        t_idle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule